// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Capture

This block holds a small set of waiting instructions for one group of functional units, for example the adders. When the issue stage sends an instruction, the block places it in a free entry. Each source operand is stored either as a value or as the tag of the station that will produce it. Architectural register numbers are never stored. The block watches a shared result bus that carries a tag and a data word. Every entry that waits on the broadcast tag takes the data in the same cycle.

An entry whose two operands both hold values is ready. When the functional unit says it can accept work, the lowest-numbered ready entry is offered for dispatch. That entry is released at the next clock edge. A younger ready entry therefore overtakes an older entry that is still waiting. The block raises a full flag when no entry is free, so the in-order issue stage holds. It also reports which station tag the next issued instruction will receive. The issue stage can hand that tag on to dependent instructions. The three stations carry tags 1 to 3. Tag 0 means "no producer".

Top module: `rsPool`

## Requirements
- R1: After reset no entry is occupied: `full` is 0, `dispValid` is 0 and `issueTag` is 1.
- R2: An accepted issue takes the lowest-index free entry. `issueTag` shows that entry's tag, 1 + index, before the issue. It reads 0 when every entry is occupied.
- R3: A source tag of 0 at issue means the operand value supplied with the issue is already valid.
- R4: A waiting operand whose stored tag equals `bcastTag` while `bcastValid` is 1 captures `bcastData` at that edge. All waiting operands in all entries with that tag capture in the same cycle.
- R5: A broadcast whose tag matches no waiting operand changes nothing, and no entry becomes ready because of it.
- R6: If a broadcast with tag T happens in the same cycle as an issue that names T as a source, the new entry stores the broadcast data and is ready.
- R7: `dispValid` is 1 only when `fuReady` is 1 and at least one occupied entry has both operands valid. `dispOp`, `dispA`, `dispB` and `dispTag` then give that entry's operation, operand values and station tag. The output is combinational in the same cycle.
- R8: When several entries are ready, the lowest index dispatches, whatever the issue order. A ready younger entry dispatches while an older one still waits.
- R9: An entry that dispatches is free at the next edge and can be allocated again.
- R10: `full` is 1 when all entries are occupied. An issue presented while `full` is 1 is ignored and creates no entry.
- R11: When `bcastValid` is 0, a matching `bcastTag` is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue stage presents an instruction |
| issueOp | input | 4 | Operation code carried to dispatch |
| issueSrcATag | input | 4 | Producer tag of source A, 0 = value valid |
| issueSrcAVal | input | 32 | Source A value when its tag is 0 |
| issueSrcBTag | input | 4 | Producer tag of source B, 0 = value valid |
| issueSrcBVal | input | 32 | Source B value when its tag is 0 |
| full | output | 1 | No free entry, issue must stall |
| issueTag | output | 4 | Tag the next issued instruction receives, 0 when full |
| bcastValid | input | 1 | Result bus carries a result |
| bcastTag | input | 4 | Tag of the station that produced the result |
| bcastData | input | 32 | Result value |
| fuReady | input | 1 | Functional unit accepts an instruction this cycle |
| dispValid | output | 1 | An instruction is dispatched this cycle |
| dispOp | output | 4 | Operation of the dispatched entry |
| dispA | output | 32 | Source A value of the dispatched entry |
| dispB | output | 32 | Source B value of the dispatched entry |
| dispTag | output | 4 | Station tag of the dispatched entry |

## Verification
The first pattern issues instructions whose operands are all immediate values. It separates allocation and freeing from any capture logic. The second pattern issues an older instruction that waits on a tag ahead of a younger one that is ready. It then sends a broadcast on a foreign tag and one on the awaited tag. This shows whether dispatch follows readiness or age, whether an unrelated broadcast is ignored, and whether two entries waiting on the same tag both capture at once. The third pattern fills the pool while the functional unit is busy. It presents a matching tag with the valid bit low, then a broadcast that coincides with an issue, then an issue while full. These steps separate the bypass path, the valid qualification and the stall behaviour. The dispatched operand values expose any wrong capture.

// File: rtl/rsPkg.sv
package rsPkg;
  parameter int unsigned NUM_ENT  = 3;
  parameter int unsigned TAG_W    = 4;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned OP_W     = 4;
  parameter int unsigned BASE_TAG = 1;

  localparam logic [TAG_W-1:0] NO_TAG = '0;

  // strobes from control to datapath, one bit per entry
  typedef struct packed {
    logic [NUM_ENT-1:0] alloc;
    logic [NUM_ENT-1:0] disp;
  } rsStrobe_t;
endpackage

// File: rtl/rsOperandSlot.sv
module rsOperandSlot
  import rsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [TAG_W-1:0]  loadTag,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  logic [TAG_W-1:0] waitTag;
  logic bypassHit;
  logic holdHit;

  assign bypassHit = bcastValid && (bcastTag == loadTag);
  assign holdHit   = bcastValid && !rdy && (bcastTag == waitTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdy     <= 1'b0;
      waitTag <= NO_TAG;
      val     <= '0;
    end else if (load) begin
      if (loadTag == NO_TAG) begin
        rdy <= 1'b1;
        val <= loadVal;
      end else if (bypassHit) begin
        rdy <= 1'b1;
        val <= bcastData;
      end else begin
        rdy     <= 1'b0;
        waitTag <= loadTag;
      end
    end else if (holdHit) begin
      rdy <= 1'b1;
      val <= bcastData;
    end
  end

  a_r3_value_tag_zero: assert property (@(posedge clk) disable iff (!rstN)
    (load && loadTag == NO_TAG) |=> (rdy && val == $past(loadVal)));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !rdy && bcastValid && bcastTag == waitTag) |=> (rdy && val == $past(bcastData)));
  a_r11_no_capture_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !rdy && !bcastValid) |=> !rdy);
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (load && loadTag != NO_TAG && bcastValid && bcastTag == loadTag) |=> (rdy && val == $past(bcastData)));
endmodule

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               fuReady,
  input  logic [NUM_ENT-1:0] opReady,
  output rsStrobe_t          strobe,
  output logic               full,
  output logic               dispValid,
  output logic [TAG_W-1:0]   issueTag
);
  logic [NUM_ENT-1:0] busy;
  logic [NUM_ENT-1:0] freeMask;
  logic [NUM_ENT-1:0] allocPick;
  logic [NUM_ENT-1:0] readyMask;
  logic [NUM_ENT-1:0] dispPick;

  assign freeMask  = ~busy;
  assign allocPick = freeMask & (~freeMask + NUM_ENT'(1));
  assign readyMask = busy & opReady;
  assign dispPick  = readyMask & (~readyMask + NUM_ENT'(1));
  assign full      = &busy;

  assign strobe.alloc = (issueValid && !full) ? allocPick : '0;
  assign strobe.disp  = fuReady ? dispPick : '0;
  assign dispValid    = |strobe.disp;

  always_comb begin
    issueTag = NO_TAG;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!busy[i]) issueTag = TAG_W'(BASE_TAG + i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= '0;
    else       busy <= (busy & ~strobe.disp) | strobe.alloc;
  end

  a_r10_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (strobe.alloc == '0));
  a_r8_single_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.disp));
  a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc & busy) == '0);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
    a_r9_freed_after_disp: assert property (@(posedge clk) disable iff (!rstN)
      strobe.disp[i] |=> !busy[i]);
  end
endmodule

// File: rtl/rsData.sv
module rsData
  import rsPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rsStrobe_t          strobe,
  input  logic [OP_W-1:0]    issueOp,
  input  logic [TAG_W-1:0]   issueSrcATag,
  input  logic [DATA_W-1:0]  issueSrcAVal,
  input  logic [TAG_W-1:0]   issueSrcBTag,
  input  logic [DATA_W-1:0]  issueSrcBVal,
  input  logic               bcastValid,
  input  logic [TAG_W-1:0]   bcastTag,
  input  logic [DATA_W-1:0]  bcastData,
  output logic [NUM_ENT-1:0] opReady,
  output logic [OP_W-1:0]    dispOp,
  output logic [DATA_W-1:0]  dispA,
  output logic [DATA_W-1:0]  dispB,
  output logic [TAG_W-1:0]   dispTag
);
  logic [NUM_ENT-1:0] aRdy;
  logic [NUM_ENT-1:0] bRdy;
  logic [DATA_W-1:0]  aVal [NUM_ENT];
  logic [DATA_W-1:0]  bVal [NUM_ENT];
  logic [OP_W-1:0]    opReg [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN)                opReg[i] <= '0;
      else if (strobe.alloc[i]) opReg[i] <= issueOp;
    end

    rsOperandSlot u_srcA (
      .clk(clk), .rstN(rstN), .load(strobe.alloc[i]),
      .loadTag(issueSrcATag), .loadVal(issueSrcAVal),
      .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
      .rdy(aRdy[i]), .val(aVal[i])
    );

    rsOperandSlot u_srcB (
      .clk(clk), .rstN(rstN), .load(strobe.alloc[i]),
      .loadTag(issueSrcBTag), .loadVal(issueSrcBVal),
      .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
      .rdy(bRdy[i]), .val(bVal[i])
    );

    a_r7_disp_operands_ready: assert property (@(posedge clk) disable iff (!rstN)
      strobe.disp[i] |-> (aRdy[i] && bRdy[i]));
  end

  assign opReady = aRdy & bRdy;

  always_comb begin
    dispOp  = '0;
    dispA   = '0;
    dispB   = '0;
    dispTag = NO_TAG;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (strobe.disp[i]) begin
        dispOp  = dispOp | opReg[i];
        dispA   = dispA | aVal[i];
        dispB   = dispB | bVal[i];
        dispTag = dispTag | TAG_W'(BASE_TAG + i);
      end
    end
  end
endmodule

// File: rtl/rsPool.sv
module rsPool
  import rsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [TAG_W-1:0]  issueSrcATag,
  input  logic [DATA_W-1:0] issueSrcAVal,
  input  logic [TAG_W-1:0]  issueSrcBTag,
  input  logic [DATA_W-1:0] issueSrcBVal,
  output logic              full,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  input  logic              fuReady,
  output logic              dispValid,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispA,
  output logic [DATA_W-1:0] dispB,
  output logic [TAG_W-1:0]  dispTag
);
  rsStrobe_t          strobe;
  logic [NUM_ENT-1:0] opReady;

  rsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .fuReady(fuReady),
    .opReady(opReady), .strobe(strobe), .full(full),
    .dispValid(dispValid), .issueTag(issueTag)
  );

  rsData u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueOp(issueOp),
    .issueSrcATag(issueSrcATag), .issueSrcAVal(issueSrcAVal),
    .issueSrcBTag(issueSrcBTag), .issueSrcBVal(issueSrcBVal),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
    .opReady(opReady), .dispOp(dispOp), .dispA(dispA), .dispB(dispB),
    .dispTag(dispTag)
  );

  a_r7_disp_needs_fu: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> fuReady);
  a_r10_full_no_tag: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (issueTag == NO_TAG));
endmodule

// File: tb/sim_rsPool.sv
module sim_rsPool;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [3:0] issueOp = '0;
  logic [3:0] issueSrcATag = '0;
  logic [31:0] issueSrcAVal = '0;
  logic [3:0] issueSrcBTag = '0;
  logic [31:0] issueSrcBVal = '0;
  logic full;
  logic [3:0] issueTag;
  logic bcastValid = 1'b0;
  logic [3:0] bcastTag = '0;
  logic [31:0] bcastData = '0;
  logic fuReady = 1'b0;
  logic dispValid;
  logic [3:0] dispOp;
  logic [31:0] dispA;
  logic [31:0] dispB;
  logic [3:0] dispTag;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  tag;
  } dispItem_t;

  dispItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsPool u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueSrcATag(issueSrcATag), .issueSrcAVal(issueSrcAVal),
    .issueSrcBTag(issueSrcBTag), .issueSrcBVal(issueSrcBVal),
    .full(full), .issueTag(issueTag), .bcastValid(bcastValid),
    .bcastTag(bcastTag), .bcastData(bcastData), .fuReady(fuReady),
    .dispValid(dispValid), .dispOp(dispOp), .dispA(dispA), .dispB(dispB),
    .dispTag(dispTag)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    issueValid = 1'b0;
    issueOp = '0;
    issueSrcATag = '0;
    issueSrcAVal = '0;
    issueSrcBTag = '0;
    issueSrcBVal = '0;
    bcastValid = 1'b0;
    bcastTag = '0;
    bcastData = '0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] aT, input logic [31:0] aV,
                       input logic [3:0] bT, input logic [31:0] bV);
    issueValid = 1'b1;
    issueOp = op;
    issueSrcATag = aT;
    issueSrcAVal = aV;
    issueSrcBTag = bT;
    issueSrcBVal = bV;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [31:0] d);
    bcastValid = 1'b1;
    bcastTag = t;
    bcastData = d;
  endtask

  task automatic expect_disp(input logic [3:0] op, input logic [31:0] a,
                             input logic [31:0] b, input logic [3:0] tag);
    dispItem_t it;
    it.op = op; it.a = a; it.b = b; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: sample shortly before each rising edge
  always @(negedge clk) begin
    #4;
    if (rstN && dispValid) begin
      dispItem_t got;
      got = {dispOp, dispA, dispB, dispTag};
      if (expQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected dispatch actual=%0h expected=none", got);
      end else begin
        chk("R7 dispatch item", 72'(got), 72'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) step();
    rstN = 1'b1;
    #1;
    chk("R1 full", 72'(full), 72'(0));
    chk("R1 dispValid", 72'(dispValid), 72'(0));
    chk("R1 issueTag", 72'(issueTag), 72'(1));

    // pattern 1: immediate operands, dispatch and free
    fuReady = 1'b1;
    issue(4'd1, 4'd0, 32'd10, 4'd0, 32'd20);
    expect_disp(4'd1, 32'd10, 32'd20, 4'd1);
    #1 chk("R2 first tag", 72'(issueTag), 72'(1));
    step(); idle();
    #1 chk("R3 ready next cycle", 72'(dispValid), 72'(1));
    chk("R7 dispTag", 72'(dispTag), 72'(1));
    step();
    #1 chk("R9 entry reusable", 72'(issueTag), 72'(1));
    chk("R9 not full", 72'(full), 72'(0));

    // pattern 2: older waits, younger passes, shared capture
    issue(4'd2, 4'd9, 32'd0, 4'd0, 32'd5);
    step(); idle();
    issue(4'd3, 4'd0, 32'd7, 4'd0, 32'd8);
    expect_disp(4'd3, 32'd7, 32'd8, 4'd2);
    #1 chk("R7 waiting entry not offered", 72'(dispValid), 72'(0));
    step(); idle();
    issue(4'd4, 4'd9, 32'd0, 4'd9, 32'd0);
    #1 chk("R2 lowest free tag", 72'(issueTag), 72'(3));
    chk("R8 younger passes older", 72'(dispTag), 72'(2));
    step(); idle();
    bcast(4'd7, 32'd99);
    #1 chk("R5 nothing ready", 72'(dispValid), 72'(0));
    step(); idle();
    #1 chk("R5 foreign tag ignored", 72'(dispValid), 72'(0));
    bcast(4'd9, 32'h55);
    expect_disp(4'd2, 32'h55, 32'd5, 4'd1);
    expect_disp(4'd4, 32'h55, 32'h55, 4'd3);
    fuReady = 1'b0;
    step(); idle();
    #1 chk("R7 fu busy holds dispatch", 72'(dispValid), 72'(0));
    step(); fuReady = 1'b1;
    #1 chk("R8 lowest index first", 72'(dispTag), 72'(1));
    chk("R4 captured value", 72'(dispA), 72'(32'h55));
    step();
    #1 chk("R8 second ready entry", 72'(dispTag), 72'(3));
    chk("R4 both operands captured", 72'(dispB), 72'(32'h55));
    step();
    #1 chk("R9 pool drained", 72'(dispValid), 72'(0));

    // pattern 3: fill, invalid match, bypass, issue while full
    fuReady = 1'b0;
    issue(4'd5, 4'd12, 32'd0, 4'd0, 32'd1);
    step(); idle();
    issue(4'd6, 4'd12, 32'd0, 4'd0, 32'd2);
    bcastValid = 1'b0; bcastTag = 4'd12; bcastData = 32'hAA;
    step(); idle();
    issue(4'd7, 4'd12, 32'd0, 4'd0, 32'd3);
    bcast(4'd12, 32'h77);
    expect_disp(4'd5, 32'h77, 32'd1, 4'd1);
    expect_disp(4'd6, 32'h77, 32'd2, 4'd2);
    expect_disp(4'd7, 32'h77, 32'd3, 4'd3);
    #1 chk("R2 third entry tag", 72'(issueTag), 72'(3));
    chk("R10 one entry still free", 72'(full), 72'(0));
    step(); idle();
    #1 chk("R10 full", 72'(full), 72'(1));
    chk("R10 no tag while full", 72'(issueTag), 72'(0));
    issue(4'd8, 4'd0, 32'd1, 4'd0, 32'd1);
    step(); idle();
    fuReady = 1'b1;
    #1 chk("R4 hold capture", 72'(dispA), 72'(32'h77));
    step();
    #1 chk("R11 invalid match not taken", 72'(dispA), 72'(32'h77));
    step();
    #1 chk("R6 bypass value", 72'(dispA), 72'(32'h77));
    chk("R6 bypass tag", 72'(dispTag), 72'(3));
    step();
    #1 chk("R10 issue while full ignored", 72'(dispValid), 72'(0));
    chk("R10 empty again", 72'(full), 72'(0));
    step();
    chk("R7 all expected dispatched", 72'(expQ.size()), 72'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule